// File: doc/BRIEF.md
# Operand Address Former

This unit turns an addressing-mode request into a 24-bit operand address for a processor with a 16-Mbyte space. Each request arrives as a one-cycle `start` pulse. It carries the mode, a 32-bit base register value, the operand size, a displacement or absolute field with its width selector, and the program counter.

For most modes the result is registered, and `done` rises in the cycle after `start`. The memory-indirect mode is different: it first raises a fetch request for a pointer held in low memory. It then waits for the response and reports the fetched word as the address. Auto-increment and auto-decrement also return a write-back value for the base register. Modes that name no memory location raise `no_addr` instead.

The controller has three states:
- **IDLE** waits for `start`. It moves to DONE for every mode except memory indirect, and to FETCH for memory indirect.
- **FETCH** holds `fetch_req` until `fetch_valid` is seen, then moves to DONE.
- **DONE** shows the result for one cycle and always moves back to IDLE.

Top module: `ea_unit`

## Requirements
- R1: After reset, `done`, `fetch_req` and `wb_en` are 0.
- R2: For any mode other than memory indirect (mode 8), `done` is 1 in exactly the one cycle after the cycle in which `start` was sampled.
- R3: Register direct (mode 0) and immediate (mode 6) give `no_addr`=1, `ea`=0 and `wb_en`=0. Every other mode gives `no_addr`=0.
- R4: Register indirect (mode 1) gives `ea` = base[23:0].
- R5: Register with displacement (mode 2) uses the field sign-extended from 16 bits when `fwidth`=1. For any other `fwidth` it uses the full 32-bit field. `ea` = (base + offset) truncated to 24 bits.
- R6: Post-increment (mode 3) gives `ea` = base[23:0], `wb_en`=1 and `wb_val` = base + step, where `osize` 0/1/2 gives step 1/2/4, taken modulo 2^32.
- R7: Pre-decrement (mode 4) computes v = base − step. It gives `ea` = v[23:0], `wb_en`=1 and `wb_val` = v.
- R8: Absolute (mode 5) is formed from the width selector:
  - `fwidth`=0 gives 0xFFFF00 + field[7:0].
  - `fwidth`=1 gives field[15:0] sign-extended to 24 bits.
  - `fwidth`=2 or 3 gives field[23:0].
- R9: PC-relative (mode 7) gives `ea` = (pc + offset) mod 2^24. The offset is field[7:0] sign-extended when `fwidth`=0, and field[15:0] sign-extended otherwise.
- R10: Memory indirect (mode 8) raises `fetch_req` from the cycle after `start` until the cycle in which `fetch_valid` is sampled. During that time `fetch_addr` = field[7:0] zero-extended, held stable, and `done` stays 0.
- R11: `done` is 1 in the cycle after `fetch_valid` is sampled, with `ea` = fetch_data, `no_addr`=0 and `wb_en`=0. `fetch_req` is 0 in that cycle.
- R12: A `start` pulse while a request is in progress (FETCH or DONE) is ignored. It neither changes the result nor produces an extra `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse; the inputs below are sampled with it |
| mode | input | 4 | Addressing mode code (0..8) |
| fwidth | input | 2 | Field width: 0=8, 1=16, 2=24, 3=32 bits |
| osize | input | 2 | Operand size: 0=byte, 1=word, 2=long |
| base | input | 32 | Base register value |
| field | input | 32 | Displacement or absolute field |
| pc | input | 24 | Program counter |
| fetch_valid | input | 1 | Pointer fetch response valid |
| fetch_data | input | 24 | Fetched pointer value |
| done | output | 1 | Result valid for one cycle |
| ea | output | 24 | Effective address |
| no_addr | output | 1 | Mode names no memory location |
| wb_en | output | 1 | Base register write-back valid |
| wb_val | output | 32 | Base register write-back value |
| fetch_req | output | 1 | Pointer fetch request |
| fetch_addr | output | 24 | Pointer fetch address |

## Verification
A controller stuck in FETCH shows at the ports as a `fetch_req` that stays high after the response, together with a `done` that never comes. A controller that leaves IDLE on a busy-time `start` shows as a second `done` pulse, or as a corrupted `ea`, within two cycles. Wrong extension or step arithmetic appears in the very `done` cycle of the affected request. Sweeps over every 8-bit absolute and PC-relative field value, and over boundary bases for each operand size, expose any such error on the first request that exercises it.

// File: rtl/ea_pkg.sv
package ea_pkg;
    localparam int EA_W  = 24;
    localparam int REG_W = 32;

    typedef enum logic [3:0] {
        AM_REG     = 4'd0,
        AM_IND     = 4'd1,
        AM_DISP    = 4'd2,
        AM_POSTINC = 4'd3,
        AM_PREDEC  = 4'd4,
        AM_ABS     = 4'd5,
        AM_IMM     = 4'd6,
        AM_PCREL   = 4'd7,
        AM_MEMIND  = 4'd8
    } amode_t;

    typedef enum logic [1:0] {FW_8 = 2'd0, FW_16 = 2'd1, FW_24 = 2'd2, FW_32 = 2'd3} fwidth_t;
    typedef enum logic [1:0] {SZ_B = 2'd0, SZ_W = 2'd1, SZ_L = 2'd2, SZ_X = 2'd3} osize_t;

    typedef struct packed {
        logic [EA_W-1:0]  ea;
        logic             no_addr;
        logic             wb_en;
        logic [REG_W-1:0] wb_val;
    } ea_res_t;
endpackage

// File: rtl/ea_ext.sv
module ea_ext
    import ea_pkg::*;
#(
    parameter int RW = REG_W,
    parameter int AW = EA_W,
    parameter int PW = 8
) (
    input  amode_t        mode,
    input  fwidth_t       fw,
    input  logic [RW-1:0] field,
    output logic [RW-1:0] off
);
    localparam int HW = 16;

    logic [RW-1:0] sx8, sx16, ones8, zx_aw, zx_ptr;

    always_comb begin
        sx8    = {{(RW-8){field[7]}}, field[7:0]};
        sx16   = {{(RW-HW){field[HW-1]}}, field[HW-1:0]};
        ones8  = {{(RW-8){1'b1}}, field[7:0]};
        zx_aw  = {{(RW-AW){1'b0}}, field[AW-1:0]};
        zx_ptr = {{(RW-PW){1'b0}}, field[PW-1:0]};
    end

    always_comb begin
        off = '0;
        unique case (mode)
            AM_DISP:   off = (fw == FW_16) ? sx16 : field;
            AM_PCREL:  off = (fw == FW_8) ? sx8 : sx16;
            AM_ABS: begin
                unique case (fw)
                    FW_8:    off = ones8;
                    FW_16:   off = sx16;
                    default: off = zx_aw;
                endcase
            end
            AM_MEMIND: off = zx_ptr;
            default:   off = '0;
        endcase
    end
endmodule

// File: rtl/ea_calc.sv
module ea_calc
    import ea_pkg::*;
#(
    parameter int RW = REG_W,
    parameter int AW = EA_W
) (
    input  amode_t        mode,
    input  osize_t        osize,
    input  logic [RW-1:0] base,
    input  logic [RW-1:0] off,
    input  logic [AW-1:0] pc,
    output ea_res_t       res
);
    logic [RW-1:0] step, inc_v, dec_v, disp_v;
    logic [AW-1:0] pcr_v;

    always_comb begin
        unique case (osize)
            SZ_B:    step = RW'(1);
            SZ_W:    step = RW'(2);
            default: step = RW'(4);
        endcase
        inc_v  = base + step;
        dec_v  = base - step;
        disp_v = base + off;
        pcr_v  = pc + off[AW-1:0];
    end

    always_comb begin
        res = '0;
        unique case (mode)
            AM_IND:     res.ea = base[AW-1:0];
            AM_DISP:    res.ea = disp_v[AW-1:0];
            AM_POSTINC: begin
                res.ea     = base[AW-1:0];
                res.wb_en  = 1'b1;
                res.wb_val = inc_v;
            end
            AM_PREDEC: begin
                res.ea     = dec_v[AW-1:0];
                res.wb_en  = 1'b1;
                res.wb_val = dec_v;
            end
            AM_ABS:     res.ea = off[AW-1:0];
            AM_PCREL:   res.ea = pcr_v;
            AM_MEMIND:  res.ea = '0;
            default:    res.no_addr = 1'b1;
        endcase
    end
endmodule

// File: rtl/ea_fsm.sv
module ea_fsm
    import ea_pkg::*;
#(
    parameter int AW = EA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          is_ind,
    input  ea_res_t       calc,
    input  logic [AW-1:0] ptr,
    input  logic          fetch_valid,
    input  logic [AW-1:0] fetch_data,
    output logic          done,
    output ea_res_t       res,
    output logic          fetch_req,
    output logic [AW-1:0] fetch_addr
);
    typedef enum logic [1:0] {S_IDLE, S_FETCH, S_DONE} state_t;

    state_t        state, nxt;
    ea_res_t       res_q;
    logic [AW-1:0] ptr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (start) nxt = is_ind ? S_FETCH : S_DONE;
            S_FETCH: if (fetch_valid) nxt = S_DONE;
            S_DONE:  nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
            ptr_q <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (start) begin
                    if (is_ind) ptr_q <= ptr;
                    else        res_q <= calc;
                end
                S_FETCH: if (fetch_valid) begin
                    res_q         <= '0;
                    res_q.ea      <= fetch_data;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        done       = (state == S_DONE);
        fetch_req  = (state == S_FETCH);
        fetch_addr = ptr_q;
        res        = res_q;
        res.wb_en  = res_q.wb_en & done;
    end

    AST_DIRECT_TO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (start && state == S_IDLE && !is_ind) |=> done); // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R12
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && !fetch_valid) |=> (fetch_req && !done)); // R10
    AST_PTR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && !fetch_valid) |=> $stable(fetch_addr)); // R10
    AST_VALID_TO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && fetch_valid) |=> (done && !fetch_req)); // R11
    AST_FETCHED_EA: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && fetch_valid) |=> (res.ea == $past(fetch_data) && !res.wb_en)); // R11
endmodule

// File: rtl/ea_unit.sv
module ea_unit
    import ea_pkg::*;
#(
    parameter int AW = EA_W,
    parameter int RW = REG_W,
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [3:0]    mode,
    input  logic [1:0]    fwidth,
    input  logic [1:0]    osize,
    input  logic [RW-1:0] base,
    input  logic [RW-1:0] field,
    input  logic [AW-1:0] pc,
    input  logic          fetch_valid,
    input  logic [AW-1:0] fetch_data,
    output logic          done,
    output logic [AW-1:0] ea,
    output logic          no_addr,
    output logic          wb_en,
    output logic [RW-1:0] wb_val,
    output logic          fetch_req,
    output logic [AW-1:0] fetch_addr
);
    amode_t        am;
    logic [RW-1:0] off;
    ea_res_t       calc, res;

    assign am = amode_t'(mode);

    ea_ext #(.RW(RW), .AW(AW), .PW(PW)) u_ext (
        .mode (am),
        .fw   (fwidth_t'(fwidth)),
        .field(field),
        .off  (off)
    );

    ea_calc #(.RW(RW), .AW(AW)) u_calc (
        .mode (am),
        .osize(osize_t'(osize)),
        .base (base),
        .off  (off),
        .pc   (pc),
        .res  (calc)
    );

    ea_fsm #(.AW(AW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .is_ind     (am == AM_MEMIND),
        .calc       (calc),
        .ptr        (off[AW-1:0]),
        .fetch_valid(fetch_valid),
        .fetch_data (fetch_data),
        .done       (done),
        .res        (res),
        .fetch_req  (fetch_req),
        .fetch_addr (fetch_addr)
    );

    assign ea      = res.ea;
    assign no_addr = res.no_addr;
    assign wb_en   = res.wb_en;
    assign wb_val  = res.wb_val;
endmodule

// File: tb/ea_unit_test.sv
`timescale 1ns/1ps
module ea_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  mode = '0;
    logic [1:0]  fwidth = '0;
    logic [1:0]  osize = '0;
    logic [31:0] base = '0;
    logic [31:0] field = '0;
    logic [23:0] pc = '0;
    logic        fetch_valid = 1'b0;
    logic [23:0] fetch_data = '0;
    logic        done, no_addr, wb_en, fetch_req;
    logic [23:0] ea, fetch_addr;
    logic [31:0] wb_val;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    ea_unit uut (.*);

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] stub_mem(logic [23:0] a);
        return 24'(a * 24'h010203 + 24'h123456);
    endfunction

    function automatic longint sx(longint v, int bits);
        longint m = longint'(1) << bits;
        v = v % m;
        return (v >= m / 2) ? v - m : v;
    endfunction

    task automatic run_op(int m, int fw, int sz, logic [31:0] b, logic [31:0] f, logic [23:0] p,
                          string req);
        longint e, off, stepv, wbv;
        bit na = 0, we = 0;
        stepv = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
        e = 0; wbv = 0;
        case (m)
            0, 6: na = 1;
            1: e = b;
            2: begin
                off = (fw == 1) ? sx(longint'(f), 16) : longint'(f);
                e = longint'(b) + off;
            end
            3: begin e = b; we = 1; wbv = (longint'(b) + stepv) % (longint'(1) << 32); end
            4: begin
                wbv = (longint'(b) - stepv + (longint'(1) << 32)) % (longint'(1) << 32);
                e = wbv; we = 1;
            end
            5: begin
                if (fw == 0) e = 24'hFFFF00 + longint'(f[7:0]);
                else if (fw == 1) e = sx(longint'(f), 16);
                else e = f[23:0];
            end
            7: e = longint'(p) + ((fw == 0) ? sx(longint'(f), 8) : sx(longint'(f), 16));
            default: ;
        endcase
        e = ((e % 64'h1000000) + 64'h1000000) % 64'h1000000;
        @(negedge clk);
        start = 1; mode = 4'(m); fwidth = 2'(fw); osize = 2'(sz);
        base = b; field = f; pc = p;
        @(negedge clk);
        start = 0;
        chk({req, " done"}, 64'(done), 64'd1);
        chk({req, " ea"}, 64'(ea), 64'(e));
        chk({req, " no_addr"}, 64'(no_addr), 64'(na));
        chk({req, " wb_en"}, 64'(wb_en), 64'(we));
        if (we) chk({req, " wb_val"}, 64'(wb_val), 64'(wbv));
        @(negedge clk);
        chk("R2 single done", 64'(done), 64'd0);
    endtask

    task automatic run_ind(logic [31:0] f, int lat, bit poke);
        logic [23:0] pa = {16'h0, f[7:0]};
        @(negedge clk);
        start = 1; mode = 4'd8; field = f; fwidth = 2'd0;
        @(negedge clk);
        start = 0;
        for (int i = 0; i < lat; i++) begin
            chk("R10 req", 64'(fetch_req), 64'd1);
            chk("R10 addr", 64'(fetch_addr), 64'(pa));
            chk("R10 no done", 64'(done), 64'd0);
            if (poke && i == 0) begin start = 1; mode = 4'd0; field = 32'hFF; end
            @(negedge clk);
            start = 0;
        end
        chk("R10 req at resp", 64'(fetch_req), 64'd1);
        fetch_valid = 1; fetch_data = stub_mem(fetch_addr);
        @(negedge clk);
        fetch_valid = 0;
        chk("R11 done", 64'(done), 64'd1);
        chk("R11 ea", 64'(ea), 64'(stub_mem(pa)));
        chk("R11 no_addr", 64'(no_addr), 64'd0);
        chk("R11 wb_en", 64'(wb_en), 64'd0);
        chk("R11 req low", 64'(fetch_req), 64'd0);
        if (poke) begin
            start = 1; mode = 4'd0;
        end
        @(negedge clk);
        start = 0;
        chk("R12 no extra done", 64'(done), 64'd0);
        chk("R12 no req", 64'(fetch_req), 64'd0);
        @(negedge clk);
        chk("R12 still idle", 64'(done), 64'd0);
    endtask

    initial begin
        automatic logic [31:0] bases[6] = '{32'h0, 32'h1, 32'h00FFFFFF, 32'h01000000,
                                            32'hFFFFFFFF, 32'h12345678};
        automatic logic [31:0] flds[6] = '{32'h0, 32'h7FFF, 32'h8000, 32'hFFFF,
                                           32'h89ABCDEF, 32'hFFFFFFFF};
        repeat (3) @(negedge clk);
        chk("R1 done", 64'(done), 64'd0);
        chk("R1 fetch_req", 64'(fetch_req), 64'd0);
        chk("R1 wb_en", 64'(wb_en), 64'd0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 done after release", 64'(done), 64'd0);

        run_op(0, 0, 0, 32'h12345678, 0, 0, "R3 reg");
        run_op(6, 3, 2, 32'hFFFFFFFF, 32'hFFFFFFFF, 24'hFFFFFF, "R3 imm");
        foreach (bases[i]) begin
            run_op(1, 0, 0, bases[i], 0, 0, "R4 ind");
            for (int sz = 0; sz < 3; sz++) begin
                run_op(3, 0, sz, bases[i], 0, 0, "R6 postinc");
                run_op(4, 0, sz, bases[i], 0, 0, "R7 predec");
            end
            foreach (flds[j]) begin
                run_op(2, 1, 0, bases[i], flds[j], 0, "R5 disp16");
                run_op(2, 3, 0, bases[i], flds[j], 0, "R5 disp32");
                run_op(5, 1, 0, 0, flds[j], 0, "R8 abs16");
                run_op(5, 2, 0, 0, flds[j], 0, "R8 abs24");
                run_op(5, 3, 0, 0, flds[j], 0, "R8 abs32");
                run_op(7, 1, 0, 0, flds[j], bases[i][23:0], "R9 pcrel16");
            end
        end
        for (int v = 0; v < 256; v++) begin
            run_op(5, 0, 0, 0, 32'hABCD0000 | 32'(v), 0, "R8 abs8");
            run_op(7, 0, 0, 0, 32'h5500 | 32'(v), 24'h000010, "R9 pcrel8");
            run_op(7, 0, 0, 0, 32'(v), 24'hFFFFF0, "R9 pcrel8 wrap");
        end
        run_ind(32'h00000000, 1, 0);
        run_ind(32'hFFFFFF80, 3, 1);
        run_ind(32'h000000FF, 5, 1);
        for (int v = 0; v < 256; v += 17) run_ind(32'(v), 1 + v % 4, v[0]);
        run_op(2, 1, 0, 32'h00FF0000, 32'hFFFF, 0, "R2 after indirect");

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog act=running exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule